// File: doc/BRIEF.md
# Programmable Dual-Mode Bus Clock Divider

This block turns the system clock into a slower bus clock for an external interface, together with a one-cycle update strobe that marks, in system-clock terms, each point where the bus may change. Two 16-bit divisor fields share one 32-bit configuration word. A mode input picks between two rules. The default halving rule disregards the divisor's lowest bit and always yields an even division. The integer rule divides by the exact value.

When separate per-region rates are enabled, a chip-select selector chooses which of the two divisor fields is active. Otherwise the lower field is always used. Any change to the divisor, the mode or the selection is picked up only when a new output period begins, so a period already under way always completes with its old timing. The bus clock is generated from a counter running on the system clock and is registered, so it never produces runt pulses.

Top module: `bus_clk_div`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `busClk` and `busStb` are both low. On the first clock edge after release both go high, because a new period starts at once.
- R2: Divisor field 0 is `divWord[15:0]` and divisor field 1 is `divWord[31:16]`.
- R3: With `intMode` = 0 and a nonzero divisor N, the output period is 2*(floor(N/2)+1) system cycles. `busClk` is high for the first floor(N/2)+1 cycles and low for the rest. The lowest bit of N therefore has no effect, so N=2 and N=3 both give a quarter rate.
- R4: A divisor of 0 in either mode gives full-rate operation: `busClk` and `busStb` are both held high on every cycle.
- R5: With `intMode` = 1 and N >= 2, the period is N system cycles. `busClk` is high for ceil(N/2) cycles and then low for floor(N/2) cycles.
- R6: With `intMode` = 1, a divisor of 1 behaves exactly like a divisor of 0 (full rate).
- R7: With `sepRates` = 1, `csSel` = 0 selects divisor field 0 and `csSel` = 1 selects divisor field 1.
- R8: With `sepRates` = 0, divisor field 0 is used whatever the value of `csSel`, and divisor field 1 has no effect on the output.
- R9: A change to `divWord`, `intMode`, `sepRates` or `csSel` takes effect only at the next rising edge of `busClk`. The period in progress completes with its old high and low lengths.
- R10: When the period is longer than one cycle, `busStb` is high for exactly one system cycle per period, the cycle in which `busClk` rises, and low on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divWord | input | 32 | Packed divisor word: field 0 in bits 15:0, field 1 in bits 31:16 |
| intMode | input | 1 | 0 selects the halving rule, 1 selects exact integer division |
| sepRates | input | 1 | 1 enables per-chip-select divisor choice |
| csSel | input | 1 | Active chip-select region (0 or 1) when `sepRates` is 1 |
| busClk | output | 1 | Divided bus clock |
| busStb | output | 1 | One-cycle update strobe at each rising edge of `busClk` |

## Verification
The bench tests the halving rule with adjacent odd and even divisors. A design that honoured the lowest bit would make N=3 differ from N=2 and would give periods of the wrong length. It tests integer mode with odd divisors, where an off-by-one in the high length would swap which phase carries the extra cycle, and with divisor 1, which must fall back to full rate rather than stall or toggle. It loads the two fields with different values and toggles `csSel` both with and without `sepRates`, which would expose swapped fields or an ignored enable. Finally it changes the divisor in the middle of a long period: a design that reloaded at once would cut that period short or move its strobe.

// File: rtl/bus_clk_div_pkg.sv
package bus_clk_div_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic reload;   // start a new output period, latch new lengths
    logic advance;  // step the phase counter
  } div_ctrl_t;
endpackage

// File: rtl/bus_clk_div_dp.sv
module bus_clk_div_dp
  import bus_clk_div_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = DIV_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*DIV_W-1:0] divWord,
  input  logic               intMode,
  input  logic               sepRates,
  input  logic               csSel,
  input  div_ctrl_t          ctrl,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   perLen,
  output logic [CNT_W-1:0]   hiLen
);
  localparam int NUM_FIELDS = 2;

  logic [DIV_W-1:0] fieldArr [NUM_FIELDS];
  logic [DIV_W-1:0] divSel;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] perNext;
  logic [CNT_W-1:0] hiNext;

  // unpack the divisor fields from the word
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign fieldArr[g] = divWord[g*DIV_W +: DIV_W];
  end

  assign divSel  = (sepRates && csSel) ? fieldArr[1] : fieldArr[0];
  assign halfLen = CNT_W'(divSel >> 1) + CNT_W'(1);

  always_comb begin
    perNext = CNT_W'(1);
    hiNext  = CNT_W'(1);
    if (intMode) begin
      if (divSel > DIV_W'(1)) begin
        perNext = CNT_W'(divSel);
        hiNext  = (CNT_W'(divSel) + CNT_W'(1)) >> 1;
      end
    end else if (divSel != '0) begin
      perNext = halfLen << 1;
      hiNext  = halfLen;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      perLen <= CNT_W'(1);
      hiLen  <= CNT_W'(1);
    end else if (ctrl.reload) begin
      cnt    <= '0;
      perLen <= perNext;
      hiLen  <= hiNext;
    end else if (ctrl.advance) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bus_clk_div_ctl.sv
module bus_clk_div_ctl
  import bus_clk_div_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] perLen,
  input  logic [CNT_W-1:0] hiLen,
  output div_ctrl_t        ctrl,
  output logic             busClk,
  output logic             busStb
);
  logic [CNT_W-1:0] cntNext;
  logic             clkNext;

  assign cntNext      = cnt + CNT_W'(1);
  assign ctrl.reload  = (cntNext >= perLen);
  assign ctrl.advance = !ctrl.reload;
  assign clkNext      = ctrl.reload || (cntNext < hiLen);

  always_ff @(posedge clk) begin
    if (rst) begin
      busClk <= 1'b0;
      busStb <= 1'b0;
    end else begin
      busClk <= clkNext;
      busStb <= ctrl.reload;
    end
  end
endmodule

// File: rtl/bus_clk_div.sv
module bus_clk_div
  import bus_clk_div_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*DIV_W-1:0] divWord,
  input  logic               intMode,
  input  logic               sepRates,
  input  logic               csSel,
  output logic               busClk,
  output logic               busStb
);
  localparam int CNT_W = DIV_W + 1;

  div_ctrl_t        ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] perLen;
  logic [CNT_W-1:0] hiLen;

  bus_clk_div_dp #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .divWord(divWord), .intMode(intMode),
    .sepRates(sepRates), .csSel(csSel), .ctrl(ctrl),
    .cnt(cnt), .perLen(perLen), .hiLen(hiLen)
  );

  bus_clk_div_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .cnt(cnt), .perLen(perLen), .hiLen(hiLen),
    .ctrl(ctrl), .busClk(busClk), .busStb(busStb)
  );
endmodule

// File: rtl/bus_clk_div_chk.sv
module bus_clk_div_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             busClk,
  input logic             busStb,
  input logic             reload,
  input logic [CNT_W-1:0] perLen,
  input logic [CNT_W-1:0] hiLen
);
  logic rstQ = 1'b0;
  always_ff @(posedge clk) rstQ <= rst;

  // R1: outputs low once reset has been sampled
  always @(negedge clk) begin
    if (rstQ && rst) begin
      p_reset_low_r1: assert (!busClk && !busStb);
    end
  end

  // R10: strobe comes with the rising edge
  p_stb_on_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busClk) |-> busStb);

  // R10: strobe only while the clock is high
  p_stb_high_r10: assert property (@(posedge clk) disable iff (rst)
    busStb |-> busClk);

  // R10: no strobe on the falling edge
  p_no_stb_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busClk) |-> !busStb);

  // R9: period lengths only change on a reload
  p_hold_lengths_r9: assert property (@(posedge clk) disable iff (rst)
    !reload |=> ($stable(perLen) && $stable(hiLen)));

  // R4: full-rate period keeps both outputs high
  p_full_rate_r4: assert property (@(posedge clk) disable iff (rst)
    (perLen == CNT_W'(1) && !$past(rst)) |-> (busClk && busStb));
endmodule

bind bus_clk_div bus_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busClk(busClk), .busStb(busStb),
  .reload(ctrl.reload), .perLen(perLen), .hiLen(hiLen)
);

// File: tb/tb_bus_clk_div.sv
`timescale 1ns/1ps
module tb_bus_clk_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] divWord = '0;
  logic        intMode = 1'b0;
  logic        sepRates = 1'b0;
  logic        csSel = 1'b0;
  logic        busClk;
  logic        busStb;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bus_clk_div dut (
    .clk(clk), .rst(rst), .divWord(divWord), .intMode(intMode),
    .sepRates(sepRates), .csSel(csSel), .busClk(busClk), .busStb(busStb)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // wait for a strobe, then verify nPer periods of length per with hi high cycles
  task automatic checkPattern(input string req, input int per, input int hi, input int nPer);
    int got = 0;
    int bad = 0;
    int actV = 0;
    int expV = 0;
    for (int w = 0; w < 300 && got == 0; w++) begin
      @(negedge clk);
      if (busStb) got = 1;
    end
    check(req, "strobe seen", got, 1);
    for (int p = 0; p < nPer; p++) begin
      for (int i = 0; i < per; i++) begin
        if (bad == 0 && (busClk != (i < hi) || busStb != (i == 0))) begin
          bad  = 1;
          actV = {busClk, busStb};
          expV = {(i < hi), (i == 0)};
        end
        @(negedge clk);
      end
    end
    check(req, $sformatf("pattern per=%0d hi=%0d {clk,stb}", per, hi), actV, expV);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "busClk in reset", busClk, 0);
    check("R1", "busStb in reset", busStb, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "first edge {clk,stb}", {busClk, busStb}, 3);
    checkPattern("R4", 1, 1, 10);
  endtask

  task automatic testDefault();
    intMode = 1'b0; sepRates = 1'b0;
    divWord = 32'd1; checkPattern("R3", 2, 1, 3);
    divWord = 32'd2; checkPattern("R3", 4, 2, 3);
    divWord = 32'd3; checkPattern("R3", 4, 2, 3);
    divWord = 32'd7; checkPattern("R3", 8, 4, 2);
    divWord = 32'd0; checkPattern("R4", 1, 1, 6);
  endtask

  task automatic testInt();
    intMode = 1'b1; sepRates = 1'b0;
    divWord = 32'd1; checkPattern("R6", 1, 1, 6);
    divWord = 32'd2; checkPattern("R5", 2, 1, 3);
    divWord = 32'd3; checkPattern("R5", 3, 2, 3);
    divWord = 32'd5; checkPattern("R5", 5, 3, 2);
    divWord = 32'd8; checkPattern("R5", 8, 4, 2);
    divWord = 32'd0; checkPattern("R4", 1, 1, 6);
  endtask

  task automatic testSelect();
    intMode = 1'b0; sepRates = 1'b1;
    divWord = {16'd5, 16'd2};
    csSel = 1'b0; checkPattern("R7", 4, 2, 2);
    csSel = 1'b1; checkPattern("R7", 6, 3, 2);
    intMode = 1'b1;
    divWord = {16'd3, 16'd4};
    checkPattern("R2", 3, 2, 2);
    csSel = 1'b0; checkPattern("R2", 4, 2, 2);
  endtask

  task automatic testIgnore();
    intMode = 1'b0; sepRates = 1'b0; csSel = 1'b1;
    divWord = {16'd9, 16'd1};
    checkPattern("R8", 2, 1, 3);
    csSel = 1'b0;
    divWord = {16'd0, 16'd5};
    checkPattern("R8", 6, 3, 2);
  endtask

  task automatic testReload();
    int bad = 0;
    int actV = 0;
    int expV = 0;
    intMode = 1'b0; sepRates = 1'b0; csSel = 1'b0;
    divWord = 32'd10;
    checkPattern("R9", 12, 6, 1);
    // now at the start of a fresh 12-cycle period
    for (int i = 0; i < 12; i++) begin
      if (bad == 0 && (busClk != (i < 6) || busStb != (i == 0))) begin
        bad  = 1;
        actV = {busClk, busStb};
        expV = {(i < 6), (i == 0)};
      end
      if (i == 3) divWord = 32'd2;
      if (i == 8) intMode = 1'b1;
      @(negedge clk);
    end
    check("R9", "old period kept {clk,stb}", actV, expV);
    check("R9", "new period starts", {busClk, busStb}, 3);
    checkPattern("R9", 2, 1, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testDefault();
    testInt();
    testSelect();
    testIgnore();
    testReload();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule